// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Match Interrupt

This block is a memory-mapped real-time clock that sits on a 32-bit APB-style register bus and decodes a 4 KiB address window. A prescaler divides the system clock by `CLK_HZ` and produces a one-cycle tick once per second. Each tick advances a free-running 32-bit absolute seconds count. A second, relative view reports how many seconds have passed since software last restarted it. Software can also load the absolute count directly.

A programmable match word raises a level interrupt on the tick that brings the seconds count to that value. One register offset serves two purposes. A read returns the interrupt flag. A write forces the flag on (nonzero data) or clears it (zero data). Two read-only identification words sit near the top of the window.

The bus-phase tracker is a small state machine with three states. `PH_IDLE` means no transfer. `PH_SETUP` is the first cycle of a selected transfer. `PH_DONE` is the cycle after an access phase. From `PH_IDLE`, `psel` high with `penable` low moves the machine to `PH_SETUP`. In `PH_SETUP`, `psel` and `penable` both high form the access phase: the transfer commits and the machine moves to `PH_DONE`. If `psel` drops in `PH_SETUP`, the machine returns to `PH_IDLE`. From `PH_DONE`, a fresh setup phase goes back to `PH_SETUP`; anything else goes to `PH_IDLE`.

Top module: `sec_rtc`

## Requirements
- R1: After reset the seconds count, match word, relative reference and interrupt flag are all zero, and `irq` is low.
- R2: Offset 0xFE0 reads 0x00041030 and offset 0xFD8 reads 0x000FFFFF. Writes to either offset change nothing.
- R3: Offset 0x4 holds the match word and reads back exactly the last 32-bit value written to it.
- R4: A write to offset 0x8 sets the interrupt flag when the data is nonzero and clears it when the data is zero. A read of 0x8 returns the flag in bit 0, with bits 31:1 zero. `irq` always equals the flag.
- R5: A write to offset 0xC loads the data into the seconds count, visible from the next cycle. The load restarts the prescaler, so the next tick comes `CLK_HZ` cycles later. The load leaves the relative reference unchanged. A read of 0xC returns zero.
- R6: The prescaler ticks once every `CLK_HZ` cycles. Each tick that does not coincide with a load adds one to the seconds count, which wraps from 0xFFFFFFFF to 0.
- R7: Offset 0x0 reads the seconds count, and writes to it are ignored.
- R8: Offset 0x10 reads the seconds count minus a stored reference, modulo 2^32. Any write to 0x10 copies the seconds value of the following cycle into the reference, so the relative count reads zero straight afterwards.
- R9: A tick whose new seconds value equals the match word sets the flag. The flag then stays set until a zero is written to 0x8. A match in the same cycle as such a clear wins.
- R10: A write whose `pstrb` is not all ones has no effect on any state.
- R11: Reads of unmapped offsets, including unaligned ones, return zero, and writes to them change nothing. `pready` is always high, so every transfer has no wait states.
- R12: State changes only in the access phase of a transfer, that is `psel` and `penable` high one cycle after a setup phase. Outside an access phase `prdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the 4 KiB window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'b1111 writes take effect |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| irq | output | 1 | Level interrupt, equal to the flag |

## Verification
The hardest situation to reach from the ports is a match that lands on the seconds wrap. The tick that rolls 0xFFFFFFFF over to 0 must set the flag when the match word is 0. The same holds when the match tick falls in the same cycle as a zero write to 0x8.

To reach the wrap, the bench loads 0xFFFFFFFE through the load offset and sets a small `CLK_HZ`. It then waits two ticks.

To reach the collision, the bench counts prescaler cycles after a load, which gives a known phase. It then places the clearing access phase exactly on a tick edge. A behavioural reference model checks `irq` and every read against its own prediction on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_AW = 12;
    localparam int RTC_DW = 32;
    localparam int RTC_SW = RTC_DW / 8;

    localparam logic [RTC_AW-1:0] OFS_SECS  = 12'h000;
    localparam logic [RTC_AW-1:0] OFS_MATCH = 12'h004;
    localparam logic [RTC_AW-1:0] OFS_FLAG  = 12'h008;
    localparam logic [RTC_AW-1:0] OFS_LOAD  = 12'h00C;
    localparam logic [RTC_AW-1:0] OFS_REL   = 12'h010;
    localparam logic [RTC_AW-1:0] OFS_MASK  = 12'hFD8;
    localparam logic [RTC_AW-1:0] OFS_IDENT = 12'hFE0;

    localparam logic [RTC_DW-1:0] IDENT_WORD = 32'h0004_1030;
    localparam logic [RTC_DW-1:0] MASK_WORD  = 32'h000F_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_DONE  = 2'd2
    } bus_phase_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_commit,
    output logic rd_active
);
    bus_phase_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PH_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PH_IDLE:  if (psel && !penable) st_nx = PH_SETUP;
            PH_SETUP: begin
                if (psel && penable) st_nx = PH_DONE;
                else if (!psel)      st_nx = PH_IDLE;
            end
            PH_DONE:  st_nx = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:  st_nx = PH_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = 1'b0;
        rd_active = 1'b0;
        unique case (st)
            PH_SETUP: begin
                wr_commit = psel && penable && pwrite;
                rd_active = psel && penable && !pwrite;
            end
            default: ;
        endcase
    end

    p_commit_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit || rd_active) |=> !(wr_commit || rd_active));
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic sw_wr,
    input  logic sw_set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (match_evt) flag <= 1'b1;
        else if (sw_wr)     flag <= sw_set;
    end

    p_match_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag);
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(sw_wr && !sw_set)) |=> flag);
    p_quiet_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_evt && !sw_wr) |=> $stable(flag));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [RTC_AW-1:0] paddr,
    input  logic [RTC_DW-1:0] pwdata,
    input  logic [RTC_SW-1:0] pstrb,
    output logic [RTC_DW-1:0] prdata,
    output logic              pready,
    output logic              irq
);
    logic wr_commit, rd_active, tick, flag;
    logic wr_full, do_load, do_match, do_flag, do_rel, match_evt;
    logic [RTC_DW-1:0] secs, secs_nx, match_q, rel_ref;

    rtc_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .wr_commit(wr_commit), .rd_active(rd_active)
    );

    rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(do_load), .tick(tick)
    );

    assign wr_full  = wr_commit && (pstrb == {RTC_SW{1'b1}});
    assign do_load  = wr_full && (paddr == OFS_LOAD);
    assign do_match = wr_full && (paddr == OFS_MATCH);
    assign do_flag  = wr_full && (paddr == OFS_FLAG);
    assign do_rel   = wr_full && (paddr == OFS_REL);

    always_comb begin
        if (do_load)   secs_nx = pwdata;
        else if (tick) secs_nx = secs + 1'b1;
        else           secs_nx = secs;
    end

    assign match_evt = tick && !do_load && (secs_nx == match_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs    <= '0;
            match_q <= '0;
            rel_ref <= '0;
        end else begin
            secs <= secs_nx;
            if (do_match) match_q <= pwdata;
            if (do_rel)   rel_ref <= secs_nx;
        end
    end

    rtc_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match_evt(match_evt),
        .sw_wr(do_flag), .sw_set(pwdata != '0), .flag(flag)
    );

    always_comb begin
        prdata = '0;
        if (rd_active) begin
            unique case (paddr)
                OFS_SECS:  prdata = secs;
                OFS_MATCH: prdata = match_q;
                OFS_FLAG:  prdata = {{(RTC_DW-1){1'b0}}, flag};
                OFS_REL:   prdata = secs - rel_ref;
                OFS_IDENT: prdata = IDENT_WORD;
                OFS_MASK:  prdata = MASK_WORD;
                default:   prdata = '0;
            endcase
        end
    end

    assign pready = 1'b1;
    assign irq    = flag;

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !do_load) |=> (secs == $past(secs) + 1'b1));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !do_load) |=> $stable(secs));
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (secs == $past(pwdata)));
    p_match_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !do_match |=> $stable(match_q));
    p_idle_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable) |-> (prdata == '0));
endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
    localparam int HZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [31:0] prdata;
    logic        pready, irq;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sec_rtc #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_secs, m_match, m_ref;
    logic        m_flag;
    int          m_pc;
    bit          m_setup_seen;

    always @(posedge clk) begin
        bit tk, wr, evt;
        logic [31:0] ns;
        if (!rst_n) begin
            m_secs = 0; m_match = 0; m_ref = 0; m_flag = 0; m_pc = 0;
            m_setup_seen = 0;
        end else begin
            wr = psel && penable && pwrite && m_setup_seen && (pstrb == 4'hF);
            tk = (m_pc == HZ - 1);
            evt = 0;
            if (wr && paddr == 12'h00C) begin
                ns = pwdata; m_pc = 0;
            end else begin
                ns = tk ? m_secs + 1 : m_secs;
                m_pc = tk ? 0 : m_pc + 1;
                evt = tk && (ns == m_match);
            end
            if (wr && paddr == 12'h004) m_match = pwdata;
            if (wr && paddr == 12'h010) m_ref = ns;
            if (evt) m_flag = 1;
            else if (wr && paddr == 12'h008) m_flag = (pwdata != 0);
            m_secs = ns;
            m_setup_seen = psel && !penable;
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h000: return m_secs;
            12'h004: return m_match;
            12'h008: return {31'b0, m_flag};
            12'h010: return m_secs - m_ref;
            12'hFE0: return 32'h0004_1030;
            12'hFD8: return 32'h000F_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // every-cycle comparison of the interrupt line and idle read data
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq vs model", {31'b0, irq}, {31'b0, m_flag});
            chk("R11 pready", {31'b0, pready}, 32'h1);
            if (!(psel && penable)) chk("R12 idle prdata", prdata, 32'h0);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; pstrb = 4'hF;
    endtask

    task automatic rd(input string req, input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1;
        v = prdata;
        chk(req, v, exp_read(a));
        @(negedge clk); psel = 0; penable = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd("R1 secs after reset", 12'h000, v);
        chk("R1 secs literal", v, 32'h0);
        rd("R1 flag after reset", 12'h008, v);
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // R2 identification words, read-only
        wr(12'hFE0, 32'hFFFF_FFFF);
        rd("R2 ident", 12'hFE0, v);
        chk("R2 ident literal", v, 32'h0004_1030);
        rd("R2 mask", 12'hFD8, v);
        chk("R2 mask literal", v, 32'h000F_FFFF);

        // R3 match readback
        wr(12'h004, 32'h0403_0201);
        rd("R3 match", 12'h004, v);
        chk("R3 match literal", v, 32'h0403_0201);

        // R10 narrow write ignored
        wr(12'h004, 32'hDEAD_BEEF, 4'b0011);
        rd("R10 narrow match", 12'h004, v);
        chk("R10 match unchanged", v, 32'h0403_0201);
        wr(12'h008, 32'h1, 4'b0001);
        chk("R10 narrow eoi", {31'b0, irq}, 32'h0);

        // R4 force and clear
        wr(12'h008, 32'h8000_0000);
        rd("R4 status set", 12'h008, v);
        chk("R4 bit0 only", v, 32'h1);
        wr(12'h008, 32'h0);
        rd("R4 status clear", 12'h008, v);
        chk("R4 cleared", v, 32'h0);

        // R5 load and prescaler restart
        wr(12'h00C, 32'd100);
        rd("R5 loaded", 12'h000, v);
        chk("R5 loaded literal", v, 32'd100);
        rd("R5 load reads zero", 12'h00C, v);
        chk("R5 load literal", v, 32'h0);
        repeat (HZ) @(negedge clk);
        rd("R6 after one second", 12'h000, v);

        // R7 writes to seconds ignored
        wr(12'h000, 32'h1234_5678);
        rd("R7 secs not written", 12'h000, v);

        // R8 relative counter
        wr(12'h010, 32'h0);
        rd("R8 relative restart", 12'h010, v);
        chk("R8 zero", v, 32'h0);
        repeat (3 * HZ) @(negedge clk);
        rd("R8 relative advance", 12'h010, v);
        wr(12'h00C, 32'd5000);
        rd("R5 ref kept", 12'h010, v);

        // R11 unmapped
        wr(12'h020, 32'hFFFF_FFFF);
        rd("R11 unmapped", 12'h020, v);
        chk("R11 unmapped literal", v, 32'h0);
        rd("R11 unaligned", 12'h002, v);

        // R9 match on wrap
        wr(12'h004, 32'h0);
        wr(12'h00C, 32'hFFFF_FFFE);
        repeat (2 * HZ + 2) @(negedge clk);
        rd("R6 wrapped", 12'h000, v);
        chk("R9 irq on wrap", {31'b0, irq}, 32'h1);
        repeat (2 * HZ) @(negedge clk);
        chk("R9 irq held", {31'b0, irq}, 32'h1);
        wr(12'h008, 32'h0);
        chk("R9 cleared by zero", {31'b0, irq}, 32'h0);

        // R9 match collides with clear: load, then commit clear on tick edge
        wr(12'h004, 32'd51);
        wr(12'h00C, 32'd50);
        // load committed at edge E0; tick at edge E0+HZ. wr() took 1 more negedge.
        // clear commit edge = 2 negedges after setup start; need it at E0+HZ.
        repeat (HZ - 3) @(negedge clk);
        wr(12'h008, 32'h0);
        chk("R9 match wins over clear", {31'b0, irq}, 32'h1);
        rd("R9 status after collision", 12'h008, v);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule